// File: doc/BRIEF.md
# Load/Store Addressing Sequencer

This block carries out the seven data-movement instructions of a 16-bit, word-addressed machine. It takes a 16-bit instruction together with the already incremented program counter and forms the effective address in one of three ways: relative to the PC, from a base register plus a short offset, or through a pointer word fetched from memory. It then moves one word between the register file and memory, or, for the address-only instruction, writes the computed address straight into a register.

Memory is reached through a memory address register and a memory data register that drive a simple request/ready port. A request stays up until the memory returns ready. Indirect forms make two trips through that port: the first trip reads the pointer, and the second reads or writes the operand at the address the pointer holds. Loads and the address-only instruction update the negative/zero/positive condition flags from the value they write. Stores leave the flags as they were. A one-cycle completion pulse marks the end of every instruction. The surrounding core uses this pulse to move on to its next instruction.

Top module: `ls_seq_core`

## Requirements
- R1: After a synchronous reset, done, busy, mem_req, mem_we and rf_we are low, and the flags read cc_n=0, cc_z=1, cc_p=0.
- R2: For opcode 0010 (load) and 0011 (store), instr[15:12] selects the mode, and the single memory access uses address pc_next + sign-extended instr[8:0], taken modulo 2^16.
- R3: For opcode 0110 (load) and 0111 (store), the single access uses the register named by instr[8:6] plus sign-extended instr[5:0] (range -32..+31), taken modulo 2^16.
- R4: For opcode 1010 (load) and 1011 (store), the block first reads the word at the PC-relative address of R2. It then makes a second access whose address is that word.
- R5: Opcode 1110 writes the PC-relative address of R2 into the register named by instr[11:9] and makes no memory access.
- R6: A load writes the final memory word into the register named by instr[11:9], with rf_we high for exactly the done cycle. A store writes the register named by instr[11:9] to memory with mem_we high only on its final access and never asserts rf_we.
- R7: Loads and opcode 1110 set exactly one of cc_n/cc_z/cc_p (negative, zero, positive) from the written value, visible in the done cycle. Stores leave the three flags unchanged.
- R8: mem_req stays high with a stable address until mem_ready. done is a single-cycle pulse, seen 2 + A*(W+1) clocks after the clock edge that accepts start, where A is the number of accesses and W is the number of wait cycles per access.
- R9: start is ignored while busy is high. A pending instruction is unaffected and produces no extra access or done.
- R10: start with any opcode other than the seven above is ignored: no busy, no access, no done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to execute instr (taken only when idle) |
| instr | input | 16 | Instruction word |
| pc_next | input | W | Incremented program counter of the instruction |
| busy | output | 1 | An instruction is in progress |
| done | output | 1 | One-cycle completion pulse |
| rf_ra_addr | output | 3 | Base register index |
| rf_ra_data | input | W | Base register value |
| rf_rb_addr | output | 3 | Store source register index |
| rf_rb_data | input | W | Store source value |
| rf_we | output | 1 | Register write enable |
| rf_waddr | output | 3 | Register write index |
| rf_wdata | output | W | Register write value |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | W | Access address (memory address register) |
| mem_wdata | output | W | Write data (memory data register) |
| mem_rdata | input | W | Read data, valid with mem_ready |
| mem_ready | input | 1 | Memory completes the access this cycle |
| cc_n | output | 1 | Negative flag |
| cc_z | output | 1 | Zero flag |
| cc_p | output | 1 | Positive flag |

## Verification
The bench targets the extreme offsets: -256 and -32 for the two offset widths, and +31 for the base form. A design that forgets sign extension lands the access hundreds of words away. It also steers addresses across the top of memory, from PC-relative and from base-relative forms, where a design that widens the sum instead of wrapping shows a wrong address. Indirect loads and stores run with slow memory, so a design that skips the pointer trip, reuses the first address, or writes on the pointer read produces a wrong access order. Further cases are a stray start during a busy store, undefined opcodes, and a store that follows a zero-flag load. These catch a design that restarts, wakes up on foreign opcodes, or lets a store disturb the flags.

// File: rtl/ls_pkg.sv
package ls_pkg;
  localparam int IR_W   = 16;
  localparam int REG_AW = 3;
  localparam int OFF9_W = 9;
  localparam int OFF6_W = 6;

  typedef enum logic [1:0] {AM_PCREL, AM_BASE, AM_INDIR, AM_LEA} amode_t;
  typedef enum logic [1:0] {ST_IDLE, ST_CALC, ST_ACC} state_t;

  typedef struct packed {
    logic   ok;
    logic   store;
    amode_t mode;
  } op_info_t;

  function automatic op_info_t decode_op(input logic [3:0] opc);
    op_info_t r;
    r = '{ok: 1'b1, store: 1'b0, mode: AM_PCREL};
    case (opc)
      4'b0010: r.mode = AM_PCREL;
      4'b0011: begin r.mode = AM_PCREL; r.store = 1'b1; end
      4'b0110: r.mode = AM_BASE;
      4'b0111: begin r.mode = AM_BASE;  r.store = 1'b1; end
      4'b1010: r.mode = AM_INDIR;
      4'b1011: begin r.mode = AM_INDIR; r.store = 1'b1; end
      4'b1110: r.mode = AM_LEA;
      default: r.ok = 1'b0;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/ls_addr_gen.sv
module ls_addr_gen
  import ls_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [OFF9_W-1:0] off_field,
  input  logic [W-1:0]      pc,
  input  logic [W-1:0]      base,
  output logic [W-1:0]      pcrel_ea,
  output logic [W-1:0]      base_ea
);
  localparam int EXT9 = W - OFF9_W;
  localparam int EXT6 = W - OFF6_W;

  logic [W-1:0] sx9, sx6;

  always_comb begin
    sx9      = {{EXT9{off_field[OFF9_W-1]}}, off_field};
    sx6      = {{EXT6{off_field[OFF6_W-1]}}, off_field[OFF6_W-1:0]};
    pcrel_ea = pc + sx9;
    base_ea  = base + sx6;
  end
endmodule

// File: rtl/ls_cc_reg.sv
module ls_cc_reg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         upd,
  input  logic [W-1:0] val,
  output logic         neg,
  output logic         zer,
  output logic         pos
);
  always_ff @(posedge clk) begin
    if (rst) begin
      neg <= 1'b0;
      zer <= 1'b1;
      pos <= 1'b0;
    end else if (upd) begin
      neg <= val[W-1];
      zer <= (val == '0);
      pos <= !val[W-1] && (val != '0);
    end
  end

  // R7: the flags always hold exactly one of negative, zero, positive
  assert_cc_onehot_R7: assert property (@(posedge clk) disable iff (rst)
    $countones({neg, zer, pos}) == 1);

  // R7: flags move only when an update is requested
  assert_cc_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !upd |=> $stable({neg, zer, pos}));
endmodule

// File: rtl/ls_seq_core.sv
module ls_seq_core
  import ls_pkg::*;
#(
  parameter int W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [IR_W-1:0]   instr,
  input  logic [W-1:0]      pc_next,
  output logic              busy,
  output logic              done,
  output logic [REG_AW-1:0] rf_ra_addr,
  input  logic [W-1:0]      rf_ra_data,
  output logic [REG_AW-1:0] rf_rb_addr,
  input  logic [W-1:0]      rf_rb_data,
  output logic              rf_we,
  output logic [REG_AW-1:0] rf_waddr,
  output logic [W-1:0]      rf_wdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [W-1:0]      mem_addr,
  output logic [W-1:0]      mem_wdata,
  input  logic [W-1:0]      mem_rdata,
  input  logic              mem_ready,
  output logic              cc_n,
  output logic              cc_z,
  output logic              cc_p
);
  state_t          st;
  logic [IR_W-1:0] ir_q;
  logic [W-1:0]    pc_q, mar, mdr;
  logic            last_q;
  op_info_t        in_info, cur;
  logic [W-1:0]    pcrel_ea, base_ea;
  logic            cc_upd;
  logic [W-1:0]    cc_val;

  assign in_info    = decode_op(instr[IR_W-1:IR_W-4]);
  assign cur        = decode_op(ir_q[IR_W-1:IR_W-4]);
  assign rf_ra_addr = ir_q[8:6];
  assign rf_rb_addr = ir_q[11:9];

  ls_addr_gen #(.W(W)) u_agen (
    .off_field (ir_q[OFF9_W-1:0]),
    .pc        (pc_q),
    .base      (rf_ra_data),
    .pcrel_ea  (pcrel_ea),
    .base_ea   (base_ea)
  );

  always_comb begin
    cc_upd = ((st == ST_CALC) && (cur.mode == AM_LEA)) ||
             ((st == ST_ACC) && mem_ready && last_q && !cur.store);
    cc_val = (st == ST_CALC) ? pcrel_ea : mem_rdata;
  end

  ls_cc_reg #(.W(W)) u_cc (
    .clk (clk),
    .rst (rst),
    .upd (cc_upd),
    .val (cc_val),
    .neg (cc_n),
    .zer (cc_z),
    .pos (cc_p)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      ir_q     <= '0;
      pc_q     <= '0;
      mar      <= '0;
      mdr      <= '0;
      last_q   <= 1'b0;
      done     <= 1'b0;
      rf_we    <= 1'b0;
      rf_waddr <= '0;
      rf_wdata <= '0;
    end else begin
      done  <= 1'b0;
      rf_we <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (start && in_info.ok) begin
            ir_q <= instr;
            pc_q <= pc_next;
            st   <= ST_CALC;
          end
        end
        ST_CALC: begin
          if (cur.mode == AM_LEA) begin
            rf_we    <= 1'b1;
            rf_waddr <= ir_q[11:9];
            rf_wdata <= pcrel_ea;
            done     <= 1'b1;
            st       <= ST_IDLE;
          end else begin
            mar    <= (cur.mode == AM_BASE) ? base_ea : pcrel_ea;
            mdr    <= rf_rb_data;
            last_q <= (cur.mode != AM_INDIR);
            st     <= ST_ACC;
          end
        end
        ST_ACC: begin
          if (mem_ready) begin
            if (!last_q) begin
              mar    <= mem_rdata;
              last_q <= 1'b1;
            end else begin
              done <= 1'b1;
              st   <= ST_IDLE;
              if (!cur.store) begin
                rf_we    <= 1'b1;
                rf_waddr <= ir_q[11:9];
                rf_wdata <= mem_rdata;
              end
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign busy      = (st != ST_IDLE);
  assign mem_req   = (st == ST_ACC);
  assign mem_we    = (st == ST_ACC) && last_q && cur.store;
  assign mem_addr  = mar;
  assign mem_wdata = mdr;

  // R8: completion is a single-cycle pulse
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R8: an unanswered request stays up with the same address and direction
  assert_req_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  // R6: register writes only accompany completion
  assert_wb_with_done_R6: assert property (@(posedge clk) disable iff (rst)
    rf_we |-> done);

  // R6: a write strobe never appears without a request
  assert_we_in_req_R6: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> mem_req);

  // R7: a completion without register write (a store) keeps the flags
  assert_store_cc_R7: assert property (@(posedge clk) disable iff (rst)
    (done && !rf_we) |-> $stable({cc_n, cc_z, cc_p}));

  // R9: nothing new is accepted while busy; after completion the block is idle
  assert_idle_after_done_R9: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
endmodule

// File: tb/sim_ls_seq_core.sv
`timescale 1ns/1ps
module sim_ls_seq_core;
  localparam int W = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [15:0] instr = '0;
  logic [W-1:0] pc_next = '0;
  logic        busy, done;
  logic [2:0]  rf_ra_addr, rf_rb_addr, rf_waddr;
  logic [W-1:0] rf_ra_data = '0, rf_rb_data = '0, rf_wdata;
  logic        rf_we;
  logic        mem_req, mem_we;
  logic [W-1:0] mem_addr, mem_wdata;
  logic [W-1:0] mem_rdata = '0;
  logic        mem_ready = 1'b0;
  logic        cc_n, cc_z, cc_p;

  always #2.5 clk = ~clk;

  ls_seq_core #(.W(W)) u0 (
    .clk(clk), .rst(rst), .start(start), .instr(instr), .pc_next(pc_next),
    .busy(busy), .done(done),
    .rf_ra_addr(rf_ra_addr), .rf_ra_data(rf_ra_data),
    .rf_rb_addr(rf_rb_addr), .rf_rb_data(rf_rb_data),
    .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
    .cc_n(cc_n), .cc_z(cc_z), .cc_p(cc_p)
  );

  typedef struct {
    logic        we;
    logic [15:0] addr;
    logic [15:0] data;
    string       tag;
  } acc_t;

  logic [15:0] rf [8];
  logic [15:0] mem [logic [15:0]];
  acc_t        expq [$];
  int          wait_d = 0;
  int          wcnt = 0;
  int          total = 0;
  int          bad = 0;
  int          cyc = 0;
  logic [2:0]  exp_cc = 3'b010;

  function automatic logic [15:0] rdm(input logic [15:0] a);
    if (mem.exists(a)) return mem[a];
    return 16'h0000;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // memory and register file models, driven away from the active edge
  always @(negedge clk) begin
    rf_ra_data = rf[rf_ra_addr];
    rf_rb_data = rf[rf_rb_addr];
    if (!rst && rf_we) rf[rf_waddr] = rf_wdata;
    if (!rst && mem_req) begin
      if (wcnt == wait_d) begin
        acc_t e;
        mem_ready = 1'b1;
        mem_rdata = rdm(mem_addr);
        if (expq.size() == 0) begin
          chk(1'b0, "R9", "unexpected memory access", {16'h0, mem_addr}, 32'h0);
        end else begin
          e = expq.pop_front();
          chk(mem_addr == e.addr, e.tag, "access address", {16'h0, mem_addr}, {16'h0, e.addr});
          chk(mem_we == e.we, "R6", "access direction", {31'h0, mem_we}, {31'h0, e.we});
          if (e.we)
            chk(mem_wdata == e.data, "R6", "store data", {16'h0, mem_wdata}, {16'h0, e.data});
        end
        if (mem_we) mem[mem_addr] = mem_wdata;
        wcnt = 0;
      end else begin
        mem_ready = 1'b0;
        mem_rdata = 16'hDEAD;
        wcnt++;
      end
    end else begin
      mem_ready = 1'b0;
      wcnt = 0;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      bad++;
      total++;
      $display("FAIL R8 watchdog expired actual=%0d expected=%0d", cyc, 20000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic exec(input logic [15:0] ins, input logic [15:0] pc,
                      input int d, input bit junk);
    logic [3:0]  op;
    logic [2:0]  dr, br;
    logic [15:0] pcrel, based, ptr, val;
    bit          load;
    int          lat, got;
    string       vtag;
    op    = ins[15:12];
    dr    = ins[11:9];
    br    = ins[8:6];
    pcrel = pc + {{7{ins[8]}}, ins[8:0]};
    based = rf[br] + {{10{ins[5]}}, ins[5:0]};
    load  = 1'b0;
    val   = '0;
    lat   = 0;
    vtag  = "R6";
    case (op)
      4'b0010: begin
        expq.push_back('{1'b0, pcrel, 16'h0, "R2"});
        val = rdm(pcrel); load = 1'b1; lat = 2 + (d + 1);
      end
      4'b1010: begin
        ptr = rdm(pcrel);
        expq.push_back('{1'b0, pcrel, 16'h0, "R4"});
        expq.push_back('{1'b0, ptr, 16'h0, "R4"});
        val = rdm(ptr); load = 1'b1; lat = 2 + 2 * (d + 1);
      end
      4'b0110: begin
        expq.push_back('{1'b0, based, 16'h0, "R3"});
        val = rdm(based); load = 1'b1; lat = 2 + (d + 1);
      end
      4'b1110: begin
        val = pcrel; load = 1'b1; lat = 2; vtag = "R5";
      end
      4'b0011: begin
        expq.push_back('{1'b1, pcrel, rf[dr], "R2"});
        lat = 2 + (d + 1);
      end
      4'b1011: begin
        ptr = rdm(pcrel);
        expq.push_back('{1'b0, pcrel, 16'h0, "R4"});
        expq.push_back('{1'b1, ptr, rf[dr], "R4"});
        lat = 2 + 2 * (d + 1);
      end
      default: begin
        expq.push_back('{1'b0, 16'h0, 16'h0, "R3"});
        val = rf[dr]; lat = 2 + (d + 1);
        expq.delete();
        expq.push_back('{1'b1, based, rf[dr], "R3"});
      end
    endcase
    if (load) exp_cc = val[15] ? 3'b100 : (val == 16'h0 ? 3'b010 : 3'b001);
    wait_d = d;
    @(negedge clk);
    start = 1'b1; instr = ins; pc_next = pc;
    got = 0;
    for (int n = 1; n <= 80; n++) begin
      @(negedge clk);
      if (n == 1) begin
        start = junk;
        instr = 16'h2E05;
        pc_next = 16'h1234;
      end
      if (done) begin
        start = 1'b0;
        got = n;
        break;
      end
    end
    chk(got == lat, "R8", "cycles to done", got, lat);
    chk(rf_we == load, "R6", "register write strobe", {31'h0, rf_we}, {31'h0, load});
    if (load) begin
      chk(rf_waddr == dr, "R6", "register write index", {29'h0, rf_waddr}, {29'h0, dr});
      chk(rf_wdata == val, vtag, "register write value", {16'h0, rf_wdata}, {16'h0, val});
    end
    chk({cc_n, cc_z, cc_p} == exp_cc, "R7", "flags", {29'h0, cc_n, cc_z, cc_p}, {29'h0, exp_cc});
    chk(expq.size() == 0, "R4", "accesses left over", expq.size(), 0);
    expq.delete();
    @(negedge clk);
    chk(!done && !busy, "R8", "done pulse length", {30'h0, done, busy}, 32'h0);
    if (junk) begin
      for (int k = 0; k < 4; k++) begin
        @(negedge clk);
        chk(!busy && !mem_req && !done, "R9", "stray start accepted",
            {29'h0, busy, mem_req, done}, 32'h0);
      end
    end
  endtask

  task automatic bad_op(input logic [15:0] ins);
    @(negedge clk);
    start = 1'b1; instr = ins; pc_next = 16'h3000;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 5; k++) begin
      chk(!busy && !mem_req && !done && !rf_we, "R10", "undefined opcode activity",
          {28'h0, busy, mem_req, done, rf_we}, 32'h0);
      @(negedge clk);
    end
  endtask

  initial begin
    rf[0] = 16'h0000; rf[1] = 16'h1234; rf[2] = 16'h8001; rf[3] = 16'h3000;
    rf[4] = 16'h0000; rf[5] = 16'h7FFF; rf[6] = 16'h2035; rf[7] = 16'hFFFF;
    mem[16'h2005] = 16'h0042;
    mem[16'h1F00] = 16'h9000;
    mem[16'h2FE0] = 16'h0000;
    mem[16'h2054] = 16'h0777;
    mem[16'h20C1] = 16'h4000;
    mem[16'h4000] = 16'hF00D;
    mem[16'h0010] = 16'h0001;
    mem[16'h001E] = 16'h0ABC;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!done && !busy && !mem_req && !mem_we && !rf_we, "R1", "outputs after reset",
        {27'h0, done, busy, mem_req, mem_we, rf_we}, 32'h0);
    chk({cc_n, cc_z, cc_p} == 3'b010, "R1", "flags after reset",
        {29'h0, cc_n, cc_z, cc_p}, 32'h2);

    exec(16'h2205, 16'h2000, 0, 1'b0); // R2 load, positive value
    exec(16'h2500, 16'h2000, 2, 1'b0); // R2 offset -256, negative value
    exec(16'h60E0, 16'h0000, 1, 1'b0); // R3 offset -32, zero value
    exec(16'h699F, 16'h0000, 0, 1'b0); // R3 offset +31
    exec(16'hAA40, 16'h2081, 1, 1'b0); // R4 indirect load
    exec(16'hED00, 16'h0100, 0, 1'b0); // R5 address-only, result zero
    exec(16'h3210, 16'h5000, 1, 1'b0); // R7 store after zero flag
    exec(16'h74C1, 16'h0000, 0, 1'b1); // R3 base store, R9 stray start
    exec(16'hBE40, 16'h2081, 2, 1'b0); // R4 indirect store
    exec(16'hA240, 16'h2081, 0, 1'b0); // R4 read back through pointer
    exec(16'h2620, 16'hFFF0, 3, 1'b0); // R2 wrap past top of memory
    exec(16'h61DF, 16'h0000, 0, 1'b0); // R3 wrap from base 0xFFFF
    exec(16'h2410, 16'h5000, 0, 1'b0); // R6 read back of earlier store
    bad_op(16'h1000);                  // R10 operate opcode
    bad_op(16'hC000);                  // R10 control opcode

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule